// File: doc/BRIEF.md
# Locked Test-and-Set Byte Sequencer

This block sits between one processor core and a shared memory bus that several masters use. For each request it runs one indivisible read-modify-write on a single byte. The core supplies an address through a valid/ready handshake. The block asks for the bus and reads the byte. It records whether that byte was zero, then writes the byte back to the same address with its top bit forced to one. When the write completes it returns a one-cycle completion pulse together with the zero-test result.

Masking interrupts on one core cannot stop other cores from reaching shared memory. For that reason the block raises a bus-lock line together with its bus request, before the read begins. It holds the lock through the read and the write, and releases it only after the write is acknowledged. No other master can therefore reach the byte between the two accesses. Software builds spinlocks and similar primitives on this flag: a result of 1 means the byte was clear and the caller now owns it. Every request takes the same bus phases, even when the byte is already marked.

Top module: `tas_seq`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1 and `bus_lock`, `bus_req`, `bus_rd`, `bus_wr` and `rsp_done` are all 0.
- R2: A request is accepted only when `req_ready` is 1, which is true only while no sequence is in progress. A `req_valid` or a changed `req_addr` seen while busy has no effect on the running sequence.
- R3: `bus_lock` and `bus_req` rise together in the cycle after a request is accepted. Both stay high until the write is acknowledged, and the lock falls only in the completion cycle.
- R4: `bus_rd` asserts only after `bus_gnt` has been seen, and drives the accepted address. `bus_rd` and `bus_wr` are never high together.
- R5: `rsp_flag` is 1 in the completion cycle when the byte read was 0x00, and 0 for any other value.
- R6: `bus_wdata` equals the byte read with bit 7 (the `MARK_BIT` parameter) forced to 1 and every other bit unchanged.
- R7: The write drives the same `bus_addr` as the read.
- R8: The write phase is always performed, including when the byte read already has bit 7 set.
- R9: `rsp_done` is a single-cycle pulse in the cycle after the write acknowledge, with `bus_lock` already low. `req_ready` returns to 1 in the cycle after that.
- R10: The block waits without limit in the grant, read and write phases, and keeps its strobes steady until `bus_ack` (or `bus_gnt` for the grant phase) arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a test-and-set request |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_flag | output | 1 | 1 when the byte read was zero; valid with rsp_done |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_lock | output | 1 | Holds the bus against other masters |
| bus_addr | output | ADDR_W | Bus address during read and write |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, taken with bus_ack in the read phase |
| bus_ack | input | 1 | Phase acknowledge from the bus |

## Verification
The bench builds the block with a 12-bit address, an 8-bit byte, the mark at bit 7 and address parking enabled. Parking drives the address bus to zero outside the read and write phases, so the bench can watch the bus address change with the strobes. The 8-bit width brings the exact boundary bytes 0x00, 0x80, 0x7F and 0xFF within reach of directed cases. Random operations stretch the grant and acknowledge delays from zero to several cycles, and they inject stray requests with a different address while the block is busy.

// File: rtl/tas_pkg.sv
package tas_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_READ  = 3'd2,
      ST_WRITE = 3'd3,
      ST_DONE  = 3'd4
   } tas_state_e;
endpackage

// File: rtl/tas_fsm.sv
module tas_fsm
   import tas_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  logic       bus_gnt,
   input  logic       bus_ack,
   output logic       accept,
   output logic       rd_take,
   output logic       in_rw,
   output logic       req_ready,
   output logic       bus_req,
   output logic       bus_lock,
   output logic       bus_rd,
   output logic       bus_wr,
   output logic       rsp_done
);
   tas_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid) state_d = ST_REQ;
         ST_REQ:   if (bus_gnt)   state_d = ST_READ;
         ST_READ:  if (bus_ack)   state_d = ST_WRITE;
         ST_WRITE: if (bus_ack)   state_d = ST_DONE;
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      req_ready = (state_q == ST_IDLE);
      accept    = req_ready && req_valid;
      bus_rd    = (state_q == ST_READ);
      bus_wr    = (state_q == ST_WRITE);
      rd_take   = bus_rd && bus_ack;
      in_rw     = bus_rd || bus_wr;
      bus_lock  = (state_q == ST_REQ) || in_rw;
      bus_req   = bus_lock;
      rsp_done  = (state_q == ST_DONE);
   end
endmodule

// File: rtl/tas_datapath.sv
module tas_datapath #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int MARK_BIT  = 7,
   parameter bit PARK_ADDR = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              rd_take,
   input  logic              in_rw,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              zero_flag
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] byte_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q    <= '0;
         byte_q    <= '0;
         zero_flag <= 1'b0;
      end else begin
         if (accept) addr_q <= req_addr;
         if (rd_take) begin
            byte_q    <= bus_rdata;
            zero_flag <= (bus_rdata == '0);
         end
      end
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_mark
      if (i == MARK_BIT) begin : g_set
         assign bus_wdata[i] = 1'b1;
      end else begin : g_keep
         assign bus_wdata[i] = byte_q[i];
      end
   end

   if (PARK_ADDR) begin : g_park
      assign bus_addr = in_rw ? addr_q : '0;
   end else begin : g_hold
      assign bus_addr = addr_q;
   end
endmodule

// File: rtl/tas_seq.sv
module tas_seq #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int MARK_BIT  = 7,
   parameter bit PARK_ADDR = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_done,
   output logic              rsp_flag,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_lock,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("tas_seq: ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("tas_seq: DATA_W must be at least 1");
   end
   if (MARK_BIT < 0 || MARK_BIT >= DATA_W) begin : g_bad_mark
      $error("tas_seq: MARK_BIT must lie inside DATA_W");
   end

   logic accept, rd_take, in_rw;

   tas_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .bus_gnt   (bus_gnt),
      .bus_ack   (bus_ack),
      .accept    (accept),
      .rd_take   (rd_take),
      .in_rw     (in_rw),
      .req_ready (req_ready),
      .bus_req   (bus_req),
      .bus_lock  (bus_lock),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .rsp_done  (rsp_done)
   );

   tas_datapath #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MARK_BIT  (MARK_BIT),
      .PARK_ADDR (PARK_ADDR)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .rd_take   (rd_take),
      .in_rw     (in_rw),
      .req_addr  (req_addr),
      .bus_rdata (bus_rdata),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .zero_flag (rsp_flag)
   );
endmodule

// File: rtl/tas_seq_chk.sv
module tas_seq_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int MARK_BIT = 7
)(
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rsp_done,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              bus_lock,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack
);
   AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (req_ready && !bus_lock && !rsp_done)); // R1
   AST_READY_UNLOCKED: assert property (@(posedge clk) disable iff (rst) req_ready |-> !bus_lock && !bus_req); // R2
   AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (rst) (bus_rd || bus_wr) |-> (bus_lock && bus_req)); // R3
   AST_LOCK_FALL_DONE: assert property (@(posedge clk) disable iff (rst) $fell(bus_lock) |-> rsp_done); // R3
   AST_RD_AFTER_GNT: assert property (@(posedge clk) disable iff (rst) $rose(bus_rd) |-> $past(bus_gnt)); // R4
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(bus_rd && bus_wr)); // R4
   AST_WDATA_MARKED: assert property (@(posedge clk) disable iff (rst) bus_wr |-> bus_wdata[MARK_BIT]); // R6
   AST_SAME_ADDR: assert property (@(posedge clk) disable iff (rst) (bus_wr && $past(bus_rd)) |-> bus_addr == $past(bus_addr)); // R7
   AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (bus_rd && bus_ack) |=> bus_wr); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done && req_ready); // R9
   AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (rst) rsp_done |-> !bus_lock); // R9
   AST_WAIT_READ: assert property (@(posedge clk) disable iff (rst) (bus_rd && !bus_ack) |=> bus_rd); // R10
   AST_WAIT_WRITE: assert property (@(posedge clk) disable iff (rst) (bus_wr && !bus_ack) |=> bus_wr && $stable(bus_wdata)); // R10
endmodule

bind tas_seq tas_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .MARK_BIT (MARK_BIT)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_ready (req_ready),
   .rsp_done  (rsp_done),
   .bus_req   (bus_req),
   .bus_gnt   (bus_gnt),
   .bus_lock  (bus_lock),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_ack   (bus_ack)
);

// File: tb/tas_seq_tb_top.sv
module tas_seq_tb_top;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic          rsp_done;
   logic          rsp_flag;
   logic          bus_req;
   logic          bus_gnt;
   logic          bus_lock;
   logic [AW-1:0] bus_addr;
   logic          bus_rd;
   logic          bus_wr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          bus_ack;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   tas_seq #(.ADDR_W(AW), .DATA_W(DW), .MARK_BIT(7), .PARK_ADDR(1'b1)) dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_done(rsp_done), .rsp_flag(rsp_flag),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_lock(bus_lock),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   function automatic logic [DW-1:0] exp_wdata(input logic [DW-1:0] d);
      return d | 8'h80;
   endfunction

   function automatic logic exp_flag(input logic [DW-1:0] d);
      return (d == 8'h00);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int gd, input int rd, input int wd, input bit stray);
      req_valid = 1'b1;
      req_addr  = a;
      chk(req_ready == 1'b1, "R2 ready in idle", int'(req_ready), 1);
      @(negedge clk);
      req_valid = stray;
      req_addr  = a ^ 12'h5A5;
      chk(bus_lock && bus_req, "R3 lock and req rise together", int'({bus_lock, bus_req}), 3);
      chk(req_ready == 1'b0, "R2 not ready while busy", int'(req_ready), 0);
      for (int i = 0; i < gd; i++) begin
         chk(!bus_rd, "R4 no read before grant", int'(bus_rd), 0);
         @(negedge clk);
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      chk(bus_rd && !bus_wr, "R4 read strobe after grant", int'({bus_rd, bus_wr}), 2);
      chk(bus_addr == a, "R4 read address", int'(bus_addr), int'(a));
      for (int i = 0; i < rd; i++) begin
         @(negedge clk);
         chk(bus_rd && bus_lock, "R10 holds read until ack", int'({bus_rd, bus_lock}), 3);
      end
      bus_rdata = d;
      bus_ack   = 1'b1;
      @(negedge clk);
      bus_ack   = 1'b0;
      bus_rdata = ~d;
      chk(bus_wr && !bus_rd, "R8 write phase follows read", int'({bus_rd, bus_wr}), 1);
      chk(bus_addr == a, "R7 write address equals read address", int'(bus_addr), int'(a));
      chk(bus_wdata == exp_wdata(d), "R6 write data marked", int'(bus_wdata), int'(exp_wdata(d)));
      for (int i = 0; i < wd; i++) begin
         @(negedge clk);
         chk(bus_wr && bus_lock && bus_wdata == exp_wdata(d), "R10 holds write until ack",
             int'(bus_wdata), int'(exp_wdata(d)));
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack   = 1'b0;
      req_valid = 1'b0;
      chk(rsp_done == 1'b1, "R9 done after write ack", int'(rsp_done), 1);
      chk(!bus_lock && !bus_req, "R9 lock dropped at done", int'({bus_lock, bus_req}), 0);
      chk(rsp_flag == exp_flag(d), "R5 zero flag", int'(rsp_flag), int'(exp_flag(d)));
      @(negedge clk);
      chk(!rsp_done && req_ready, "R9 single pulse then ready", int'({rsp_done, req_ready}), 1);
   endtask

   initial begin
      int unused;
      unused    = $urandom(32'd4711);
      rst       = 1'b1;
      req_valid = 1'b0;
      req_addr  = '0;
      bus_gnt   = 1'b0;
      bus_ack   = 1'b0;
      bus_rdata = '0;
      repeat (3) @(negedge clk);
      chk(req_ready && !bus_lock && !bus_req && !bus_rd && !bus_wr && !rsp_done,
          "R1 reset state", int'({req_ready, bus_lock, bus_req, bus_rd, bus_wr, rsp_done}), 32);
      rst = 1'b0;
      @(negedge clk);
      run_op(12'h000, 8'h00, 0, 0, 0, 1'b0);
      run_op(12'hFFF, 8'h80, 2, 1, 3, 1'b1);
      run_op(12'h123, 8'h7F, 1, 0, 0, 1'b1);
      run_op(12'h800, 8'hFF, 0, 3, 1, 1'b0);
      run_op(12'h001, 8'h01, 4, 2, 2, 1'b1);
      for (int k = 0; k < 40; k++) begin
         run_op(AW'($urandom), DW'($urandom), int'($urandom % 4), int'($urandom % 4),
                int'($urandom % 4), 1'($urandom));
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule